// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial link, in the common I2C style, that gives an external master access to a small on-chip byte memory. The block samples the bus clock and data lines with the system clock. It finds start and stop conditions and compares the device address byte against a fixed upper field joined to three strap inputs. On a match it takes a word address and data bytes, or returns data bytes, one after another. It drives the data line only through an output enable that pulls the line low.

Writes collect in a one-page staging buffer and reach the array only at the stop condition, and only if the write-lock input is low at that point. Inside a transaction the write pointer wraps within its page. Reads run over the whole array, and the address moves on after every byte. A read ends when the master answers a byte with no acknowledge.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the data output enable is released, the block is idle, every memory byte reads as 0x00, and the current address is 0.
- R2: Before a start condition (data falling while clock is high), the block ignores all bus activity and never drives the data line.
- R3: The device address byte is sent MSB first as {4'b1010, strap[2:0], rw}. On a match the block pulls data low for the whole ninth clock pulse. rw=0 selects write and rw=1 selects read.
- R4: A device address byte with a different upper field or strap value gets no acknowledge. Later bytes also get none until the next start.
- R5: In a write, the byte after the device address is the word address (its low 7 bits are used), and each later byte is a data byte. Every byte is acknowledged. The data reach the array at the stop condition (data rising while clock is high).
- R6: If the write-lock input is high at the stop condition, the array is left unchanged. Reads still work normally.
- R7: Within one write transaction the word address moves up after each data byte in its low 3 bits only, so it wraps inside an 8-byte page. A later byte overwrites an earlier byte at the same location.
- R8: Read data are sent MSB first. The address moves up after each byte sent and wraps from 127 to 0.
- R9: If the master does not acknowledge a read byte, the block releases the data line and drives nothing more until a new start.
- R10: A repeated start after the word address, followed by a read device byte, starts the read at that word address.
- R11: The data output enable never changes while the synchronised clock stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Low three bits of the device address |
| wr_lock_i | input | 1 | High blocks all array writes |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
Every strap setting is tried against every low address field, and a wrong upper field is tried as well. This shows that the acknowledge depends on the exact match and not on any one bit. The whole array is filled page by page with an arithmetic pattern and then read back in one pass that runs past the top, so address carry, the wrap to zero and each cell's content are tested separately. An overlong page write shows the in-page wrap and the overwrite. The same write made with the lock high shows commit suppression next to reads that still work. Bus traffic before any start, after a failed match and after a final no-acknowledge shows whether the block stays silent.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edges while clock held high frame a transaction
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/tw_stage.sv
module tw_stage #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [7:0]              data_i,
  input  logic                    clear_i,
  output logic [SLOTS-1:0]        valid_o,
  output logic [SLOTS-1:0][7:0]   data_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic       vld_q;
    logic [7:0] dat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (clear_i) begin
        vld_q <= 1'b0;
      end else if (load_i && slot_i == SLOT_W'(g)) begin
        vld_q <= 1'b1;
        dat_q <= data_i;
      end
    end
    assign valid_o[g] = vld_q;
    assign data_o[g]  = dat_q;
  end
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  input  logic                  commit_i,
  input  logic [PAGE_W-1:0]     page_i,
  input  logic [SLOTS-1:0]      valid_i,
  input  logic [SLOTS-1:0][7:0] data_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (valid_i[i % SLOTS] && page_i == PAGE_W'(i / SLOTS))
          mem_q[i] <= data_i[i % SLOTS];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_mem_pkg::*;
#(
  parameter int unsigned STRAP_W    = 3,
  parameter logic [6-STRAP_W:0] DEV_HI = 4'b1010,
  parameter int unsigned MEM_DEPTH  = 128,
  parameter int unsigned PAGE_BYTES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_lock_i,
  output logic               sda_oe_o
);
  localparam int unsigned ADDR_W = $clog2(MEM_DEPTH);
  localparam int unsigned SLOT_W = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start, stop;

  tw_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  tw_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  tw_state_e          st_q;
  logic [3:0]         bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q, txreg_q;
  logic [ADDR_W-1:0]  waddr_q;
  logic [PAGE_W-1:0]  stg_page_q;
  logic               oe_q, rw_q, mack_q;

  logic                           byte_done, dev_match, stg_load, commit;
  logic [BYTE_W-1:0]              rd_data;
  logic [PAGE_BYTES-1:0]          stg_valid;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] stg_data;

  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
  assign dev_match = (shreg_q[7:1] == {DEV_HI, strap_i});
  assign stg_load  = !stop && !start && (st_q == ST_WDAT) && byte_done;
  assign commit    = stop && !wr_lock_i;

  tw_stage #(.SLOTS(PAGE_BYTES)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stg_load),
    .slot_i (waddr_q[SLOT_W-1:0]),
    .data_i (shreg_q),
    .clear_i(stop),
    .valid_o(stg_valid),
    .data_o (stg_data)
  );

  tw_mem_array #(.DEPTH(MEM_DEPTH), .SLOTS(PAGE_BYTES)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(waddr_q),
    .rd_data_o(rd_data),
    .commit_i (commit),
    .page_i   (stg_page_q),
    .valid_i  (stg_valid),
    .data_i   (stg_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      waddr_q    <= '0;
      stg_page_q <= '0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b1;
    end else if (stop) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (start) begin
      st_q      <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (st_q == ST_DEV) begin
              if (dev_match) begin
                oe_q <= 1'b1;
                rw_q <= shreg_q[0];
                st_q <= ST_DEV_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_WADR) begin
              waddr_q <= shreg_q[ADDR_W-1:0];
              oe_q    <= 1'b1;
              st_q    <= ST_WADR_ACK;
            end else begin
              stg_page_q <= waddr_q[ADDR_W-1:SLOT_W];
              waddr_q    <= {waddr_q[ADDR_W-1:SLOT_W],
                             waddr_q[SLOT_W-1:0] + SLOT_W'(1)};
              oe_q       <= 1'b1;
              st_q       <= ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              txreg_q <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              st_q    <= ST_RDAT;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            st_q      <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              waddr_q <= waddr_q + ADDR_W'(1);
              st_q    <= ST_RACK;
            end else begin
              txreg_q   <= {txreg_q[BYTE_W-2:0], 1'b0};
              oe_q      <= ~txreg_q[BYTE_W-2];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= sda_s;
          end else if (scl_fall) begin
            if (!mack_q) begin
              txreg_q   <= rd_data;
              oe_q      <= ~rd_data[BYTE_W-1];
              bit_cnt_q <= '0;
              st_q      <= ST_RDAT;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
  import tw_mem_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  sda_oe_o,
  input tw_state_e             st_q,
  input logic                  commit,
  input logic                  stop,
  input logic                  wr_lock_i,
  input logic [PAGE_BYTES-1:0] stg_valid
);
  a_r11_oe_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);

  a_r6_lock_blocks_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lock_i |-> !commit);

  a_r5_commit_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> stop);

  a_r5_stage_empty_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (stg_valid == '0));
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .sda_oe_o (sda_oe_o),
  .st_q     (st_q),
  .commit   (commit),
  .stop     (stop),
  .wr_lock_i(wr_lock_i),
  .stg_valid(stg_valid)
);

// File: tb/tw_mem_slave_test.sv
`timescale 1ns/1ps
module tw_mem_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       lock = 1'b0;
  logic       sda_oe;
  logic       sda_line;

  int checks = 0;
  int failures = 0;
  int oe_cnt = 0;
  logic [7:0] exp_mem [128];

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  tw_mem_slave uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .wr_lock_i(lock),
    .sda_oe_o (sda_oe)
  );

  always @(posedge clk) if (sda_oe) oe_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(6);
    scl = 1'b1;   tick(12);
    sda_m = 1'b0; tick(12);
    scl = 1'b0;   tick(6);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(6);
    scl = 1'b1;   tick(12);
    sda_m = 1'b1; tick(12);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(6); sda_m = b[i];
      tick(6); scl = 1'b1;
      tick(12); scl = 1'b0;
    end
    tick(6); sda_m = 1'b1;
    tick(6); scl = 1'b1;
    tick(6); ack = !sda_line;
    tick(6); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    b = '0;
    tick(6); sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(6); scl = 1'b1;
      tick(6); b = {b[6:0], sda_line};
      tick(6); scl = 1'b0;
    end
    tick(6); sda_m = nack;
    tick(6); scl = 1'b1;
    tick(12); scl = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] a, input bit rw);
    return {4'b1010, a, rw};
  endfunction

  // write n bytes starting at addr; bytes come from wbuf
  task automatic write_seq(input logic [6:0] addr, input int n, input logic [7:0] wbuf [16],
                           input string req);
    bit ack;
    bus_start();
    send_byte(dev(strap, 1'b0), ack); check(ack, req, ack, 1);
    send_byte({1'b0, addr}, ack);     check(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);        check(ack, req, ack, 1);
    end
    bus_stop();
    if (!lock)
      for (int i = 0; i < n; i++)
        exp_mem[{addr[6:3], 3'(addr[2:0] + 3'(i))}] = wbuf[i];
  endtask

  task automatic read_seq(input logic [6:0] addr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev(strap, 1'b0), ack); check(ack, "R10 dev", ack, 1);
    send_byte({1'b0, addr}, ack);     check(ack, "R10 waddr", ack, 1);
    bus_start();
    send_byte(dev(strap, 1'b1), ack); check(ack, "R10 dev rd", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i == n - 1);
      check(b == exp_mem[7'(addr + 7'(i))], req, b, exp_mem[7'(addr + 7'(i))]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [7:0] wbuf [16];
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    bus_start();
    send_byte(dev(3'd0, 1'b1), ack); check(ack, "R1 dev rd", ack, 1);
    recv_byte(b, 1'b1);              check(b == 8'h00, "R1 mem zero at addr0", b, 0);
    bus_stop();

    // R2: traffic before any start is ignored
    scl = 1'b0; tick(6);
    oe_cnt = 0;
    send_byte(dev(3'd0, 1'b0), ack);
    send_byte(8'h00, ack);
    check(oe_cnt == 0, "R2 no drive before start", oe_cnt, 0);
    bus_stop();

    // R3/R4: sweep strap against the low address field
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte(dev(3'(a), 1'b0), ack);
        check(ack == (a == s), (a == s) ? "R3 match ack" : "R4 mismatch nack", ack, a == s);
        bus_stop();
      end
    end
    strap = 3'd5;
    bus_start();
    send_byte({4'b1011, 3'd5, 1'b0}, ack); check(!ack, "R4 wrong upper field", ack, 0);
    oe_cnt = 0;
    send_byte(8'h00, ack);
    send_byte(8'hA5, ack);
    check(oe_cnt == 0, "R4 silent after mismatch", oe_cnt, 0);
    bus_stop();

    // R5 / R10: short write then random read
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h81;
    write_seq(7'd5, 3, wbuf, "R5 write ack");
    read_seq(7'd5, 3, "R5 readback");

    // R7: overlong page write wraps inside page 0x18..0x1F
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_seq(7'h1C, 10, wbuf, "R7 write ack");
    read_seq(7'h18, 8, "R7 page wrap readback");

    // R6: locked write leaves array unchanged
    lock = 1'b1;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h55;
    write_seq(7'h06, 3, wbuf, "R6 locked ack");
    read_seq(7'h05, 3, "R6 locked readback");
    lock = 1'b0;

    // full array fill, then one read across the top
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = 8'(((p * 8 + i) * 37 + 11) & 255);
      write_seq(7'(p * 8), 8, wbuf, "R5 fill ack");
    end
    read_seq(7'd0, 130, "R8 sequential read");

    // R8 wrap from 127 to 0
    read_seq(7'h7E, 4, "R8 wrap readback");

    // R9: after no-acknowledge the slave stays silent
    bus_start();
    send_byte(dev(strap, 1'b1), ack); check(ack, "R9 dev rd", ack, 1);
    recv_byte(b, 1'b1);
    oe_cnt = 0;
    recv_byte(b, 1'b1);
    check(oe_cnt == 0, "R9 released after nack", oe_cnt, 0);
    check(b == 8'hFF, "R9 line idle after nack", b, 8'hFF);
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule